// File: doc/BRIEF.md
# Flash Protection Guard

This block keeps the 8-bit control word that decides which parts of a flash array may be programmed or erased. It also judges every incoming program or erase request against that word. While reset is held, the word is copied from a nonvolatile configuration byte that arrives on an input pin. After reset, software can read the word and rewrite it, subject to per-field rules.

Two windows set the protection ranges:

- The upper window ends at the last address of the flash space.
- The lower window starts at a fixed address below it.

Each window has its own enable bit and its own 2-bit size code. A single open bit reverses what the windows mean. With the open bit set, the enabled windows are the protected ranges. With the open bit clear, the enabled windows are the only writable ranges.

Requests arrive on a valid/ready stream that carries a 23-bit global address and a command kind. Verdicts leave on a second valid/ready stream, one result per accepted request, in order.

- A verdict is held stable while `res_ready` is low.
- A new request is taken only when the result slot is empty or is being drained in the same cycle.
- A denied request sets a sticky violation flag. Software clears the flag with a write-1 pulse.

Top module: `flash_guard`

## Requirements
- R1: While `rst_n` is low, the control word is loaded from `nv_cfg`. After reset, `reg_rdata` equals that byte, `viol_flag` is 0 and `res_valid` is 0.
- R2: Bit 6 of the control word is read-only, and a register write never changes it.
- R3: The control word fields are:
  - bit 7: open.
  - bit 5: upper-window disable.
  - bits 4:3: upper size code. These bits change on a write only if bit 5 was already 1 before the write.
  - bit 2: lower-window disable.
  - bits 1:0: lower size code. These bits change on a write only if bit 2 was already 1 before the write.
  - Bits 7, 5 and 2 are always writable.
- R4: When open=1, an address inside an enabled window is protected and an address outside every enabled window is unprotected.
- R5: When open=0, an address inside an enabled window is unprotected and every other address is protected.
- R6: Window sizes and positions:
  - Upper window size: code 00/01/10/11 gives 2/4/8/16 KB. The window ends at 0x7F_FFFF.
  - Lower window size: code 00/01/10/11 gives 1/2/4/8 KB. The window begins at 0x7F_8000.
  - A window is enabled when its disable bit is 0.
- R7: With both windows disabled, every address is protected when open=0 and unprotected when open=1.
- R8: Command kinds on `cmd_kind` are 00 program, 01 sector erase, 10 mass erase and 11 reserved, which is judged like a program. A mass erase is allowed only when open=1 and both windows are disabled. A program or sector erase is allowed exactly when its address is unprotected.
- R9: Accepting a request that is denied sets `viol_flag`. The flag stays 1 until a cycle with `viol_clr`=1 and no new denial. A denial in the same cycle as a clear wins.
- R10: The result appears with `res_valid`=1 one cycle after acceptance. `cmd_ready` = !res_valid || res_ready. While `res_ready` is 0, `res_valid` stays 1 and `res_allow` holds its value.
- R11: A request, allowed or denied, never changes the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the control word |
| nv_cfg | input | 8 | Nonvolatile configuration byte copied during reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Current control word |
| viol_clr | input | 1 | Write-1 pulse clearing the violation flag |
| viol_flag | output | 1 | Sticky protection-violation flag |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request accepted when high with `cmd_valid` |
| cmd_kind | input | 2 | Request kind (program, sector erase, mass erase) |
| cmd_addr | input | 23 | Request global address |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Verdict consumer ready |
| res_allow | output | 1 | 1 = request allowed, 0 = denied |

## Verification
The bench builds the block with its default parameters:

- a 23-bit address;
- the upper window anchored at 0x7F_FFFF with a 2 KB base unit;
- the lower window anchored at 0x7F_8000 with a 1 KB base unit.

With these values, every one of the sixteen size-code pairs can be swept under both polarities of the open bit. At each setting the bench probes the first and last byte of each window and its neighbour just outside. The two windows never overlap at these values, so each edge can be checked on its own. A stalled consumer is also applied, to hold verdicts on the output stream.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    CMD_PROG = 2'b00,
    CMD_SECT = 2'b01,
    CMD_MASS = 2'b10,
    CMD_RSVD = 2'b11
  } cmd_kind_e;

  typedef struct packed {
    logic       open;
    logic       rsv_nv;
    logic       hi_dis;
    logic [1:0] hi_sel;
    logic       lo_dis;
    logic [1:0] lo_sel;
  } prot_word_t;

endpackage

// File: rtl/fg_prot_reg.sv
module fg_prot_reg
  import flash_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] nv_cfg,
  input  logic       we,
  input  logic [7:0] wdata,
  output prot_word_t word
);
  prot_word_t wr;
  prot_word_t nxt;

  assign wr = prot_word_t'(wdata);

  // Size codes only move while their window is already disabled.
  always_comb begin
    nxt        = word;
    nxt.open   = wr.open;
    nxt.hi_dis = wr.hi_dis;
    nxt.lo_dis = wr.lo_dis;
    if (word.hi_dis) nxt.hi_sel = wr.hi_sel;
    if (word.lo_dis) nxt.lo_sel = wr.lo_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  word <= prot_word_t'(nv_cfg);
    else if (we) word <= nxt;
  end
endmodule

// File: rtl/fg_window.sv
module fg_window #(
  parameter int unsigned          ADDR_W    = 23,
  parameter logic [ADDR_W-1:0]    ANCHOR    = '1,
  parameter bit                   AT_TOP    = 1'b1,
  parameter int unsigned          UNIT_LOG2 = 11,
  parameter int unsigned          SEL_W     = 2
) (
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned EW = ADDR_W + 1;
  localparam logic [EW-1:0] ONE = EW'(1);
  localparam logic [EW-1:0] ANC = {1'b0, ANCHOR};

  logic [EW-1:0] span;
  logic [EW-1:0] a_ext;

  assign span  = ONE << (UNIT_LOG2 + 32'(sel));
  assign a_ext = {1'b0, addr};

  generate
    if (AT_TOP) begin : g_top
      logic [EW-1:0] first;
      assign first = ANC + ONE - span;
      assign hit   = en && (a_ext >= first) && (a_ext <= ANC);
    end else begin : g_bottom
      logic [EW-1:0] past_end;
      assign past_end = ANC + span;
      assign hit      = en && (a_ext >= ANC) && (a_ext < past_end);
    end
  endgenerate
endmodule

// File: rtl/fg_decide.sv
module fg_decide
  import flash_guard_pkg::*;
(
  input  prot_word_t word,
  input  logic       hi_hit,
  input  logic       lo_hit,
  input  logic [1:0] kind,
  output logic       allow
);
  logic in_any, addr_prot, any_en, mass_prot;

  always_comb begin
    in_any    = hi_hit | lo_hit;
    addr_prot = word.open ? in_any : !in_any;
    any_en    = !word.hi_dis | !word.lo_dis;
    // Windows are far smaller than the array, so open=0 always leaves some sector protected.
    mass_prot = word.open ? any_en : 1'b1;
    allow     = (cmd_kind_e'(kind) == CMD_MASS) ? !mass_prot : !addr_prot;
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned       ADDR_W       = 23,
  parameter logic [ADDR_W-1:0] HI_END       = 23'h7F_FFFF,
  parameter logic [ADDR_W-1:0] LO_BASE      = 23'h7F_8000,
  parameter int unsigned       HI_UNIT_LOG2 = 11,
  parameter int unsigned       LO_UNIT_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        nv_cfg,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              viol_clr,
  output logic              viol_flag,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_allow
);
  prot_word_t word;
  logic hi_hit, lo_hit, allow, accept;

  fg_prot_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .nv_cfg(nv_cfg),
    .we    (reg_we),
    .wdata (reg_wdata),
    .word  (word)
  );

  fg_window #(
    .ADDR_W(ADDR_W), .ANCHOR(HI_END), .AT_TOP(1'b1),
    .UNIT_LOG2(HI_UNIT_LOG2), .SEL_W(2)
  ) u_hi_win (
    .en(!word.hi_dis), .sel(word.hi_sel), .addr(cmd_addr), .hit(hi_hit)
  );

  fg_window #(
    .ADDR_W(ADDR_W), .ANCHOR(LO_BASE), .AT_TOP(1'b0),
    .UNIT_LOG2(LO_UNIT_LOG2), .SEL_W(2)
  ) u_lo_win (
    .en(!word.lo_dis), .sel(word.lo_sel), .addr(cmd_addr), .hit(lo_hit)
  );

  fg_decide u_decide (
    .word  (word),
    .hi_hit(hi_hit),
    .lo_hit(lo_hit),
    .kind  (cmd_kind),
    .allow (allow)
  );

  assign reg_rdata = word;
  assign cmd_ready = !res_valid || res_ready;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_allow <= 1'b0;
      viol_flag <= 1'b0;
    end else begin
      if (accept) begin
        res_valid <= 1'b1;
        res_allow <= allow;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
      if (accept && !allow) viol_flag <= 1'b1;
      else if (viol_clr)    viol_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       viol_clr,
  input logic       viol_flag,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_kind,
  input logic       res_valid,
  input logic       res_ready,
  input logic       res_allow
);
  a_r2_reserved_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[6] == $past(reg_rdata[6]));

  a_r3_hi_size_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_rdata[5]) |=> reg_rdata[4:3] == $past(reg_rdata[4:3]));

  a_r3_lo_size_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_rdata[2]) |=> reg_rdata[1:0] == $past(reg_rdata[1:0]));

  a_r8_mass_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 2'b10 && !reg_rdata[7]) |=> (res_valid && !res_allow));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag);

  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_allow)));

  a_r10_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready == (!res_valid || res_ready));

  a_r11_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(reg_rdata));
endmodule

bind flash_guard flash_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .viol_clr(viol_clr), .viol_flag(viol_flag), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .res_valid(res_valid),
  .res_ready(res_ready), .res_allow(res_allow)
);

// File: tb/test_flash_guard.sv
`timescale 1ns/1ps
module test_flash_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  nv_cfg = 8'hD9;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        viol_clr = 1'b0;
  logic        viol_flag;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = 2'b00;
  logic [22:0] cmd_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_allow;

  always #5 clk = ~clk;

  flash_guard i_flash_guard (
    .clk(clk), .rst_n(rst_n), .nv_cfg(nv_cfg), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .viol_clr(viol_clr),
    .viol_flag(viol_flag), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_allow(res_allow)
  );

  int   n_vec = 0;
  int   n_bad = 0;
  bit   exp_q[$];
  string tag_q[$];
  logic [7:0] shadow;
  bit   exp_viol = 1'b0;
  bit   stall = 1'b0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_allow(input logic [7:0] w, input int unsigned a, input logic [1:0] k);
    bit hen, len, inh, inl;
    int unsigned hsz, lsz;
    hen = !w[5]; len = !w[2];
    hsz = 32'd2048 << w[4:3];
    lsz = 32'd1024 << w[1:0];
    inh = hen && (a >= 32'h80_0000 - hsz) && (a <= 32'h7F_FFFF);
    inl = len && (a >= 32'h7F_8000) && (a < 32'h7F_8000 + lsz);
    if (k == 2'b10) return w[7] ? !(hen || len) : 1'b0;
    return w[7] ? !(inh || inl) : (inh || inl);
  endfunction

  // consumer readiness changes shortly after the rising edge
  always @(posedge clk) begin
    #2 res_ready = !stall;
  end

  // monitor: a transfer completes at the edge following a negedge with valid and ready
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", 1, 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(res_allow == e, t, res_allow, e);
      end
    end
  end

  task automatic send(input logic [22:0] a, input logic [1:0] k, input string tag);
    bit e;
    bit acc;
    e = model_allow(shadow, a, k);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_kind = k;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (!e) exp_viol = 1'b1;
    forever begin
      acc = cmd_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    shadow = {d[7], shadow[6], d[5], shadow[5] ? d[4:3] : shadow[4:3],
              d[2], shadow[2] ? d[1:0] : shadow[1:0]};
    check(reg_rdata == shadow, "R3 written word", reg_rdata, shadow);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    shadow = nv_cfg;
    @(negedge clk);
    // R1 reset load
    check(reg_rdata == 8'hD9, "R1 reset word", reg_rdata, 8'hD9);
    check(viol_flag == 1'b0, "R1 reset flag", viol_flag, 0);
    check(res_valid == 1'b0, "R1 reset result", res_valid, 0);

    // R4: open=1, upper 16KB and lower 2KB protected
    send(23'h7F_C000, 2'b00, "R4 upper first byte");
    send(23'h7F_BFFF, 2'b00, "R4 below upper");
    send(23'h7F_87FF, 2'b01, "R4 lower last byte");
    send(23'h7F_8800, 2'b01, "R4 past lower");
    send(23'h7F_FFFF, 2'b11, "R8 reserved kind as program");
    drain();
    check(viol_flag == exp_viol, "R9 flag set by denial", viol_flag, exp_viol);
    // R11 denials leave the word untouched
    check(reg_rdata == shadow, "R11 word after denials", reg_rdata, shadow);

    // R9 flag stays until cleared
    repeat (3) @(negedge clk);
    check(viol_flag == 1'b1, "R9 flag sticky", viol_flag, 1);
    viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
    exp_viol = 1'b0;
    check(viol_flag == 1'b0, "R9 flag cleared", viol_flag, 0);

    // R2 reserved bit, R3 locked size codes
    wr(8'b1_0_0_00_0_00);
    check(reg_rdata[6] == 1'b1, "R2 reserved bit kept", reg_rdata[6], 1);
    check(reg_rdata[4:3] == 2'b11, "R3 upper size locked", reg_rdata[4:3], 3);
    wr(8'b1_0_1_01_1_10);
    wr(8'b1_0_0_00_0_10);
    check(reg_rdata[4:3] == 2'b00 && reg_rdata[1:0] == 2'b10, "R3 sizes written when disabled",
          reg_rdata[4:0], 5'b00010);

    // R5/R6 sweep every size pair under both polarities
    for (int op = 0; op < 2; op++) begin
      for (int hs = 0; hs < 4; hs++) begin
        for (int ls = 0; ls < 4; ls++) begin
          int unsigned hsz, lsz;
          hsz = 32'd2048 << hs;
          lsz = 32'd1024 << ls;
          wr({op[0], 1'b0, 1'b1, hs[1:0], 1'b1, ls[1:0]});
          wr({op[0], 1'b0, 1'b0, hs[1:0], 1'b0, ls[1:0]});
          send(23'(32'h80_0000 - hsz),     2'b00, op ? "R6 upper edge" : "R5 upper edge");
          send(23'(32'h80_0000 - hsz - 1), 2'b01, op ? "R6 upper outside" : "R5 upper outside");
          send(23'(32'h7F_8000 + lsz - 1), 2'b00, op ? "R6 lower edge" : "R5 lower edge");
          send(23'(32'h7F_8000 + lsz),     2'b01, op ? "R6 lower outside" : "R5 lower outside");
        end
      end
    end
    // R8 mass erase with windows enabled
    send(23'h7C_0000, 2'b10, "R8 mass open=1 enabled");
    wr(8'b0_0_0_00_0_00);
    send(23'h7C_0000, 2'b10, "R8 mass open=0");

    // R7 both windows disabled
    wr(8'b0_0_1_00_1_00);
    send(23'h7C_1234, 2'b00, "R7 closed all protected");
    send(23'h7F_FFFF, 2'b01, "R7 closed top protected");
    send(23'h7C_0000, 2'b10, "R8 mass open=0 disabled");
    wr(8'b1_0_1_00_1_00);
    send(23'h7C_1234, 2'b00, "R7 open all free");
    send(23'h7F_8000, 2'b01, "R7 open lower free");
    send(23'h7C_0000, 2'b10, "R8 mass open=1 disabled");
    drain();

    // R10 back-pressure: verdict held while consumer stalls
    wr(8'b0_0_1_00_1_00);
    stall = 1'b1;
    @(negedge clk);
    send(23'h7D_0000, 2'b00, "R10 held verdict");
    for (int i = 0; i < 3; i++) begin
      check(res_valid == 1'b1, "R10 valid held", res_valid, 1);
      check(res_allow == 1'b0, "R10 value held", res_allow, 0);
      check(cmd_ready == 1'b0, "R10 ready low while full", cmd_ready, 0);
      @(negedge clk);
    end
    stall = 1'b0;
    drain();
    check(res_valid == 1'b0, "R10 slot empty after drain", res_valid, 0);
    check(reg_rdata == shadow, "R11 word after run", reg_rdata, shadow);

    done = 1'b1;
    finish_run();
  end
endmodule